// File: doc/BRIEF.md
# Charger Interrupt Debounce Unit

This block filters six raw comparator flags from a battery charger: charger present, overvoltage, reverse current, reverse-supply short circuit, constant-current/constant-voltage mode and charge current above threshold. Each flag gets its own debounce time and its own edge policy. The filtered value is kept as a sense bit. A sticky interrupt bit records each qualifying filtered edge, and a mask bit decides whether that interrupt reaches the single active-high request line.

A free-running divider turns the system clock into a base tick. Every debounce time is a parameter counted in ticks. Software reads the sense and interrupt words, writes the mask word, and clears interrupts by writing ones. The short-circuit channel switches between a short and a long debounce time, depending on which detection threshold is selected.

Bit order in every word: 0 charger present, 1 overvoltage, 2 reverse current, 3 short circuit, 4 CV mode (1 = constant voltage, 0 = constant current), 5 current above threshold. Register addresses: 0 sense (read only), 1 interrupt (write one to clear), 2 mask (read/write, 1 = masked), 3 reads zero.

Top module: `chg_irq_debounce`

## Requirements
- R1: After reset, sense reads 6'b100000, the interrupt word reads 0, the mask word reads 6'h3F and irq is low.
- R2: A sense bit takes a new raw value only after the raw input has differed from it for that channel's full debounce time. If the raw input returns before the time completes, the count restarts from zero.
- R3: Edge policy. Bits 0, 1 and 4 interrupt on both filtered edges. Bits 2 and 3 interrupt on the rising edge only. Bit 5 interrupts on the falling edge only.
- R4: While reg_en is low, sense bit 5 is forced to 1 on the next clock and its count is cleared.
- R5: A transition whose debounce time is zero appears on the clock after the raw change. These are the falls of bits 1, 2 and 3 and the rise of bit 5.
- R6: The rise debounce time of bit 3 is SHORT_HI_T ticks when short_thr_hi is 1, and SHORT_LO_T ticks when it is 0.
- R7: irq is high exactly when some interrupt bit is set and its mask bit is 0.
- R8: An interrupt bit sets on a qualifying edge even while its mask bit is 1.
- R9: Writing to address 1 clears each interrupt bit whose data bit is 1. Other bits are left as they are.
- R10: If an interrupt bit sets and is cleared by a write in the same cycle, it ends up set.
- R11: Address 2 stores and returns the mask. Writes to address 0 leave the sense word unchanged.
- R12: The base tick occurs once every TICK_DIV clocks, and debounce times are counted in these ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| raw_in | input | 6 | Raw comparator flags |
| short_thr_hi | input | 1 | Selects the long short-circuit debounce time |
| reg_en | input | 1 | Charge path regulator enabled |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 6 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 6 | Register read data |
| irq | output | 1 | Combined interrupt request |

## Verification
A count that runs wrong shows up as a sense bit that moves one or more ticks early or late. The checks therefore bracket each transition: the bit must still hold its old value one tick before the deadline and must hold its new value at the deadline. A wrong edge policy or a lost restart sets or misses an interrupt bit on the very clock the sense bit moves, so the interrupt word is read right after every transition. A bad clear or mask path is visible on irq in the cycle after the write.

// File: rtl/chg_irq_debounce.sv
module chg_irq_debounce #(
  parameter int TICK_DIV   = 1250,
  parameter int DET_T      = 3200,
  parameter int OV_T       = 780,
  parameter int REV_T      = 290,
  parameter int SHORT_LO_T = 15,
  parameter int SHORT_HI_T = 290,
  parameter int CCCV_T     = 200000,
  parameter int CURR_T     = 1600
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [5:0] raw_in,
  input  logic       short_thr_hi,
  input  logic       reg_en,
  input  logic       wr_en,
  input  logic [1:0] wr_addr,
  input  logic [5:0] wr_data,
  input  logic [1:0] rd_addr,
  output logic [5:0] rd_data,
  output logic       irq
);

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int NCH  = 6;
  localparam int TMAX = imax(imax(imax(DET_T, OV_T), imax(REV_T, SHORT_LO_T)),
                             imax(imax(SHORT_HI_T, CCCV_T), CURR_T));
  localparam int CW   = $clog2(TMAX + 1);
  localparam int DW   = $clog2(TICK_DIV + 1);
  localparam logic [NCH-1:0] RISE_EV = 6'b011111;
  localparam logic [NCH-1:0] FALL_EV = 6'b110011;

  logic [DW-1:0]  div_q;
  logic           tick;
  logic [CW-1:0]  cnt_q [NCH];
  logic [CW-1:0]  cnt_d [NCH];
  logic [CW-1:0]  rise_t [NCH];
  logic [CW-1:0]  fall_t [NCH];
  logic [CW-1:0]  need;
  logic [NCH-1:0] sense_q, sense_d, int_q, mask_q, set_ev, clr;

  assign tick = (div_q == DW'(TICK_DIV - 1));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)    div_q <= '0;
    else if (tick) div_q <= '0;
    else           div_q <= div_q + 1'b1;

  always_comb begin
    rise_t[0] = CW'(DET_T);   fall_t[0] = CW'(DET_T);
    rise_t[1] = CW'(OV_T);    fall_t[1] = '0;
    rise_t[2] = CW'(REV_T);   fall_t[2] = '0;
    rise_t[3] = short_thr_hi ? CW'(SHORT_HI_T) : CW'(SHORT_LO_T);
    fall_t[3] = '0;
    rise_t[4] = CW'(CCCV_T);  fall_t[4] = CW'(CCCV_T);
    rise_t[5] = '0;           fall_t[5] = CW'(CURR_T);
  end

  always_comb begin
    need = '0;
    for (int i = 0; i < NCH; i++) begin
      sense_d[i] = sense_q[i];
      cnt_d[i]   = '0;
      need       = raw_in[i] ? rise_t[i] : fall_t[i];
      if (raw_in[i] != sense_q[i]) begin
        if (need == '0) begin
          sense_d[i] = raw_in[i];
        end else if (tick) begin
          if (cnt_q[i] == need - 1'b1) sense_d[i] = raw_in[i];
          else                         cnt_d[i]   = cnt_q[i] + 1'b1;
        end else begin
          cnt_d[i] = cnt_q[i];
        end
      end
    end
    if (!reg_en) begin
      sense_d[5] = 1'b1;
      cnt_d[5]   = '0;
    end
  end

  assign set_ev = (sense_d & ~sense_q & RISE_EV) | (~sense_d & sense_q & FALL_EV);
  assign clr    = (wr_en && wr_addr == 2'd1) ? wr_data : '0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sense_q <= 6'b100000;
      int_q   <= '0;
      mask_q  <= '1;
      for (int i = 0; i < NCH; i++) cnt_q[i] <= '0;
    end else begin
      sense_q <= sense_d;
      int_q   <= (int_q & ~clr) | set_ev;
      if (wr_en && wr_addr == 2'd2) mask_q <= wr_data;
      for (int i = 0; i < NCH; i++) cnt_q[i] <= cnt_d[i];
    end

  assign irq = |(int_q & ~mask_q);

  always_comb
    case (rd_addr)
      2'd0:    rd_data = sense_q;
      2'd1:    rd_data = int_q;
      2'd2:    rd_data = mask_q;
      default: rd_data = '0;
    endcase

endmodule

module chg_irq_debounce_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [5:0] raw,
  input logic       reg_en,
  input logic [5:0] sense,
  input logic [5:0] intr,
  input logic       irq
);
  a_r2_det_follows_raw: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sense[0]) |-> sense[0] == $past(raw[0]));
  a_r2_cccv_follows_raw: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sense[4]) |-> sense[4] == $past(raw[4]));
  a_r3_rev_no_fall_irq: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sense[2]) |-> !$rose(intr[2]));
  a_r3_curr_no_rise_irq: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sense[5]) |-> !$rose(intr[5]));
  a_r4_curr_forced: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_en |=> sense[5]);
  a_r8_rev_rise_sets: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sense[2]) |-> intr[2]);
  a_r7_irq_has_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> |intr);
endmodule

bind chg_irq_debounce chg_irq_debounce_chk chk_i (
  .clk(clk), .rst_n(rst_n), .raw(raw_in), .reg_en(reg_en),
  .sense(sense_q), .intr(int_q), .irq(irq)
);

// File: tb/chg_irq_debounce_tb.sv
module chg_irq_debounce_tb_top;
  localparam int DIV = 2;
  localparam int TD = 6, TO = 5, TR = 4, TSL = 3, TSH = 7, TC = 8, TI = 5;

  logic clk = 0, rst_n = 0, short_thr_hi = 0, reg_en = 1, wr_en = 0, irq;
  logic [5:0] raw_in = 6'b100000, wr_data = '0, rd_data;
  logic [1:0] wr_addr = '0, rd_addr = '0;
  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  chg_irq_debounce #(.TICK_DIV(DIV), .DET_T(TD), .OV_T(TO), .REV_T(TR),
    .SHORT_LO_T(TSL), .SHORT_HI_T(TSH), .CCCV_T(TC), .CURR_T(TI)) dut_i (
    .clk(clk), .rst_n(rst_n), .raw_in(raw_in), .short_thr_hi(short_thr_hi),
    .reg_en(reg_en), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq));

  // channel, idle level, ticks away, ticks back, irq away, irq back
  localparam int V_IDLE[6] = '{0, 0, 0, 0, 0, 1};
  localparam int V_TA[6]   = '{TD, TO, TR, TSL, TC, TI};
  localparam int V_TB[6]   = '{TD, 0, 0, 0, TC, 0};
  localparam int V_IA[6]   = '{1, 1, 1, 1, 1, 1};
  localparam int V_IB[6]   = '{1, 1, 0, 0, 1, 0};

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int k = 0; k < n; k++) begin @(posedge clk); #2; end
  endtask

  task automatic rd(input logic [1:0] a, output logic [5:0] d);
    rd_addr = a; #1; d = rd_data;
  endtask

  task automatic wr(input logic [1:0] a, input logic [5:0] d);
    wr_en = 1; wr_addr = a; wr_data = d; cyc(1); wr_en = 0;
  endtask

  task automatic step(input int ch, input logic lvl, input int t, input int iexp, input string req);
    logic [5:0] d;
    raw_in[ch] = lvl;
    if (t > 0) begin
      cyc((t - 1) * DIV);
      rd(0, d); chk({req, " R2 R12 early"}, d[ch], !lvl);
      rd(1, d); chk({req, " R2 early int"}, d[ch], 0);
      cyc(DIV);
    end else cyc(1);
    rd(0, d); chk({req, " R2 R5 R12 settled"}, d[ch], lvl);
    rd(1, d); chk({req, " R3 int"}, d[ch], iexp);
    chk({req, " R8 masked irq"}, irq, 0);
    wr(1, 6'h3F);
    rd(1, d); chk({req, " R9 cleared"}, d, 0);
  endtask

  initial begin
    #1600000;
    n_fail++;
    $display("FAIL R12 watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [5:0] d;
    cyc(3); rst_n = 1; cyc(1);
    rd(0, d); chk("R1 sense", d, 6'b100000);
    rd(1, d); chk("R1 int", d, 0);
    rd(2, d); chk("R1 mask", d, 6'h3F);
    chk("R1 irq", irq, 0);

    for (int r = 0; r < 6; r++) begin
      step(r, !V_IDLE[r], V_TA[r], V_IA[r], $sformatf("row%0d away", r));
      step(r, V_IDLE[r], V_TB[r], V_IB[r], $sformatf("row%0d back", r));
    end

    // R6 long short-circuit time
    short_thr_hi = 1;
    step(3, 1, TSH, 1, "R6 short hi");
    step(3, 0, 0, 0, "R6 short fall");
    short_thr_hi = 0;

    // R2 restart on glitch
    raw_in[0] = 1; cyc(3 * DIV); raw_in[0] = 0; cyc(3 * DIV);
    raw_in[0] = 1; cyc(5 * DIV);
    rd(0, d); chk("R2 restart hold", d[0], 0);
    rd(1, d); chk("R2 restart no int", d[0], 0);
    cyc(DIV);
    rd(0, d); chk("R2 restart done", d[0], 1);
    wr(1, 6'h3F);
    raw_in[0] = 0; cyc((TD + 1) * DIV); wr(1, 6'h3F);

    // R4 forced current sense
    raw_in[5] = 0; cyc((TI + 1) * DIV); wr(1, 6'h3F);
    rd(0, d); chk("R4 pre low", d[5], 0);
    reg_en = 0; cyc(1);
    rd(0, d); chk("R4 forced", d[5], 1);
    rd(1, d); chk("R4 R3 no int on forced rise", d[5], 0);
    cyc(10 * DIV);
    rd(0, d); chk("R4 held", d[5], 1);
    reg_en = 1; cyc(TI * DIV);
    rd(0, d); chk("R4 released", d[5], 0);
    rd(1, d); chk("R4 fall int", d[5], 1);
    raw_in[5] = 1; cyc(1); wr(1, 6'h3F);

    // R10 set wins over clear
    raw_in[1] = 1; cyc((TO + 1) * DIV); wr(1, 6'h3F);
    raw_in[1] = 0; wr(1, 6'h02);
    rd(1, d); chk("R10 set wins", d[1], 1);
    wr(1, 6'h02);
    rd(1, d); chk("R9 clear alone", d[1], 0);

    // R11 mask and sense writes
    wr(2, 6'h15);
    rd(2, d); chk("R11 mask readback", d, 6'h15);
    wr(0, 6'h3F);
    rd(0, d); chk("R11 sense write ignored", d, 6'b100000);
    rd(3, d); chk("R11 addr3 zero", d, 0);

    // R7 irq gating
    wr(2, 6'h3D);
    raw_in[1] = 1; cyc((TO + 1) * DIV);
    chk("R7 unmasked irq", irq, 1);
    wr(2, 6'h3F);
    chk("R7 masked again", irq, 0);
    wr(2, 6'h3D);
    chk("R7 unmasked again", irq, 1);
    wr(1, 6'h02);
    chk("R7 R9 irq after clear", irq, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule